// File: doc/BRIEF.md
# Decaying-Hold Peak Detector

This block takes a stream of unsigned samples from a speech channel that has already been low-pass filtered, and produces a one-cycle strobe at each waveform peak. A peak follower holds the largest recent sample. When a new sample is not larger, the held value sags by a fraction set by a shift amount, so the follower output becomes a sawtooth. A first-difference high-pass filter keeps only the rising edges of that sawtooth, which sharpens every peak into a short positive burst. The follower and filter pair runs twice in cascade. A threshold comparator and a retriggerable-blocked one-shot then turn each burst into a single strobe.

A sample enters when `in_valid` is high. Every stage is a registered step that carries its own valid bit, so a sample may arrive on every clock. The decay shift sets how far apart two peaks must be to be resolved separately. The threshold rejects small ripples. The hold-off count suppresses strobes for a fixed number of samples after each one.

Top module: `pkdet_top`

## Requirements
- R1: When a valid sample is strictly greater than a follower's held value, the held value becomes that sample.
- R2: When a valid sample is not greater than the held value, the held value drops by max(held >> decay_shift, 1), with decay_shift in 0..7, and never goes below zero.
- R3: Each high-pass filter outputs cur − prev when cur > prev and 0 otherwise, where prev is its previous valid input (zero after reset).
- R4: The chain is follower → filter → follower → filter, and both followers use the same decay_shift.
- R5: A strobe is a candidate only when the second filter output is strictly greater than peak_thr.
- R6: After a strobe, the next `holdoff` valid samples produce no strobe, whatever their value. With holdoff = 0, no sample is blocked.
- R7: The strobe for a sample taken at rising edge k is high for exactly the cycle after edge k+4. No strobe appears without a sample.
- R8: A synchronous active-high reset clears every held value, every filter history, the hold-off count and the strobe.
- R9: While in_valid is low, no held value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | 12 | Unsigned filtered sample |
| decay_shift | input | 3 | Decay rate as a right-shift amount |
| peak_thr | input | 12 | Comparator threshold |
| holdoff | input | 8 | Samples blocked after each strobe |
| peak_strobe | output | 1 | One-cycle peak marker |

## Verification
Each sample passes through four registered stages and the strobe register, so its result appears on `peak_strobe` in the cycle after the fourth rising edge following the edge that took it. The monitor keeps a five-bit history of accepted valid bits. In every cycle it compares the strobe against the next queued expectation when that history says a sample's result is due, and against zero otherwise. Decay, threshold and hold-off settings change only after the pipeline has drained, so every expectation is computed with the settings the hardware saw.

// File: rtl/pkdet_pkg.sv
package pkdet_pkg;
    parameter int SMP_W   = 12;
    parameter int SHIFT_W = 3;

    typedef logic [SMP_W-1:0]   smp_t;
    typedef logic [SHIFT_W-1:0] shamt_t;

    typedef struct packed {
        logic vld;
        smp_t val;
    } flow_t;

    // held value after one decay step: fraction set by shift, at least 1, floored at 0
    function automatic smp_t decay_next(smp_t held, shamt_t sh);
        smp_t step;
        step = held >> sh;
        if (step == '0) step = smp_t'(1);
        return (held > step) ? (held - step) : '0;
    endfunction

    // positive part of the first difference
    function automatic smp_t rise_part(smp_t cur, smp_t prev);
        return (cur > prev) ? (cur - prev) : '0;
    endfunction
endpackage

// File: rtl/pkdet_follower.sv
module pkdet_follower
    import pkdet_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flow_t  d_i,
    input  shamt_t shift_i,
    output flow_t  q_o
);
    smp_t held_q;
    logic vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= d_i.vld;
            if (d_i.vld) begin
                if (d_i.val > held_q) held_q <= d_i.val;
                else                  held_q <= decay_next(held_q, shift_i);
            end
        end
    end

    assign q_o = '{vld: vld_q, val: held_q};
endmodule

// File: rtl/pkdet_sharpen.sv
module pkdet_sharpen
    import pkdet_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  flow_t d_i,
    output flow_t q_o
);
    smp_t prev_q;
    smp_t diff_q;
    logic vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            diff_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= d_i.vld;
            if (d_i.vld) begin
                diff_q <= rise_part(d_i.val, prev_q);
                prev_q <= d_i.val;
            end
        end
    end

    assign q_o = '{vld: vld_q, val: diff_q};
endmodule

// File: rtl/pkdet_oneshot.sv
module pkdet_oneshot
    import pkdet_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  flow_t             d_i,
    input  smp_t              thr_i,
    input  logic [HOLD_W-1:0] holdoff_i,
    output logic              strobe_o
);
    logic [HOLD_W-1:0] block_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            block_q  <= '0;
            strobe_o <= 1'b0;
        end else begin
            strobe_o <= 1'b0;
            if (d_i.vld) begin
                if (block_q != '0) begin
                    block_q <= block_q - 1'b1;
                end else if (d_i.val > thr_i) begin
                    strobe_o <= 1'b1;
                    block_q  <= holdoff_i;
                end
            end
        end
    end
endmodule

// File: rtl/pkdet_top.sv
module pkdet_top
    import pkdet_pkg::*;
#(
    parameter int HOLD_W     = 8,
    parameter int NUM_PASSES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [pkdet_pkg::SMP_W-1:0]   in_sample,
    input  logic [pkdet_pkg::SHIFT_W-1:0] decay_shift,
    input  logic [pkdet_pkg::SMP_W-1:0]   peak_thr,
    input  logic [HOLD_W-1:0]             holdoff,
    output logic                          peak_strobe
);
    localparam int N_LINKS = 2 * NUM_PASSES + 1;

    flow_t link [N_LINKS];
    smp_t  first_hold;

    assign link[0]    = '{vld: in_valid, val: in_sample};
    assign first_hold = link[1].val;

    for (genvar p = 0; p < NUM_PASSES; p++) begin : g_pass
        pkdet_follower u_follow (
            .clk     (clk),
            .rst     (rst),
            .d_i     (link[2*p]),
            .shift_i (decay_shift),
            .q_o     (link[2*p+1])
        );
        pkdet_sharpen u_sharp (
            .clk (clk),
            .rst (rst),
            .d_i (link[2*p+1]),
            .q_o (link[2*p+2])
        );
    end

    pkdet_oneshot #(.HOLD_W(HOLD_W)) u_shot (
        .clk       (clk),
        .rst       (rst),
        .d_i       (link[N_LINKS-1]),
        .thr_i     (peak_thr),
        .holdoff_i (holdoff),
        .strobe_o  (peak_strobe)
    );
endmodule

// File: rtl/pkdet_checker.sv
module pkdet_checker #(
    parameter int HOLD_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [11:0]       in_sample,
    input logic [HOLD_W-1:0] holdoff,
    input logic [11:0]       first_hold,
    input logic              peak_strobe
);
    logic rst_d = 1'b0;

    always_ff @(posedge clk) begin
        if (rst_d) begin
            assert_reset_clear_R8: assert (peak_strobe == 1'b0 && first_hold == '0);
        end
        rst_d <= rst;
    end

    assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sample > first_hold) |=> (first_hold == $past(in_sample)));

    assert_decay_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sample <= first_hold && first_hold != '0) |=> (first_hold < $past(first_hold)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(first_hold));

    assert_block_next_R6: assert property (@(posedge clk) disable iff (rst)
        (peak_strobe && holdoff != '0 && $stable(holdoff)) |=> !peak_strobe);

    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        peak_strobe |-> $past(in_valid, 5));
endmodule

bind pkdet_top pkdet_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_sample   (in_sample),
    .holdoff     (holdoff),
    .first_hold  (first_hold),
    .peak_strobe (peak_strobe)
);

// File: tb/tb_pkdet_top.sv
module tb_pkdet_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_sample = '0;
    logic [2:0]  decay_shift = '0;
    logic [11:0] peak_thr = '0;
    logic [7:0]  holdoff = '0;
    logic        peak_strobe;

    always #10 clk = ~clk;

    pkdet_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .decay_shift(decay_shift), .peak_thr(peak_thr), .holdoff(holdoff),
        .peak_strobe(peak_strobe)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    exp_q[$];
    logic [4:0] vhist = '0;
    string tag = "R8 reset";
    int    strobes_seen = 0;

    int m_t1, m_p1, m_t2, m_p2, m_cnt;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int m_trk(int held, int x, int sh);
        int step;
        if (x > held) return x;
        step = held >> sh;
        if (step == 0) step = 1;
        return (held > step) ? held - step : 0;
    endfunction

    function automatic int m_hp(int cur, int prev);
        return (cur > prev) ? cur - prev : 0;
    endfunction

    task automatic model_reset();
        m_t1 = 0; m_p1 = 0; m_t2 = 0; m_p2 = 0; m_cnt = 0;
        exp_q.delete();
    endtask

    // driver: computes the expected strobe from R1..R6 and queues it
    task automatic send(int x);
        int h1, h2;
        bit e;
        m_t1 = m_trk(m_t1, x, int'(decay_shift));
        h1   = m_hp(m_t1, m_p1); m_p1 = m_t1;
        m_t2 = m_trk(m_t2, h1, int'(decay_shift));
        h2   = m_hp(m_t2, m_p2); m_p2 = m_t2;
        e = 1'b0;
        if (m_cnt != 0) m_cnt--;
        else if (h2 > int'(peak_thr)) begin e = 1'b1; m_cnt = int'(holdoff); end
        exp_q.push_back(e);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 12'(x);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: result of a sample taken at edge k is due after edge k+4 (R7)
    always @(posedge clk) begin
        #5;
        if (rst) begin
            vhist = '0;
            chk(peak_strobe == 1'b0, "R8 strobe low in reset", int'(peak_strobe), 0);
        end else begin
            vhist = {vhist[3:0], in_valid};
            if (vhist[4]) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected result slot", int'(peak_strobe), 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    if (peak_strobe) strobes_seen++;
                    chk(peak_strobe == e, tag, int'(peak_strobe), int'(e));
                end
            end else begin
                chk(peak_strobe == 1'b0, "R7 no strobe without sample", int'(peak_strobe), 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    function automatic int tri_wave(int i, int per, int amp);
        int ph, half;
        ph = i % per; half = per / 2;
        return (ph < half) ? (ph * amp) / half : ((per - ph) * amp) / half;
    endfunction

    initial begin
        logic [15:0] lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(peak_strobe == 1'b0, "R8 strobe after reset", int'(peak_strobe), 0);

        // periodic peaks, moderate decay
        tag = "R1 R3 R4 R5 periodic peaks";
        decay_shift = 3'd3; peak_thr = 12'd20; holdoff = 8'd0;
        for (int i = 0; i < 200; i++) send(tri_wave(i, 16, 2000));
        idle(8);

        // fastest and slowest decay, small amplitudes exercise the minimum step
        tag = "R2 fast decay";
        decay_shift = 3'd0; peak_thr = 12'd5;
        for (int i = 0; i < 150; i++) send(tri_wave(i, 10, 900) + (i % 3));
        idle(8);
        tag = "R2 slow decay minimum step";
        decay_shift = 3'd7; peak_thr = 12'd1;
        for (int i = 0; i < 150; i++) send(tri_wave(i, 12, 60));
        idle(8);

        // dense peaks with hold-off
        tag = "R6 holdoff blocks strobes";
        decay_shift = 3'd1; peak_thr = 12'd10; holdoff = 8'd5;
        for (int i = 0; i < 200; i++) send(tri_wave(i, 4, 3000));
        idle(8);

        // threshold at maximum: comparator never fires
        tag = "R5 threshold above range";
        peak_thr = 12'hFFF; holdoff = 8'd0;
        for (int i = 0; i < 100; i++) send(tri_wave(i, 8, 4095));
        idle(8);

        // random samples with gaps in valid
        tag = "R9 valid gaps";
        decay_shift = 3'd2; peak_thr = 12'd30; holdoff = 8'd2;
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0] && lfsr[3]) idle(1 + int'(lfsr[5:4]));
            send(int'(lfsr[11:0]) & 12'hFFF);
        end
        idle(8);

        // mid-stream reset clears every held value
        tag = "R8 restart after reset";
        for (int i = 0; i < 30; i++) send(3000);
        idle(8);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        model_reset();
        decay_shift = 3'd3; peak_thr = 12'd20; holdoff = 8'd0;
        for (int i = 0; i < 100; i++) send(tri_wave(i, 20, 1500));
        idle(10);

        chk(exp_q.size() == 0, "R7 all results delivered", exp_q.size(), 0);
        chk(strobes_seen > 0, "R5 strobes observed", strobes_seen, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule